// File: doc/BRIEF.md
# SPI Status and Interrupt Flag Controller

This block owns the status, flag and interrupt logic of a double-buffered SPI peripheral. The serial datapath sends it single-cycle event pulses: one when a byte leaves the transmit holding register for the shift register, one when a finished byte lands in the receive holding register, and one when a mode fault is seen on the slave-select pin. From these pulses the block keeps four flags: receive-full, transmit-empty, overflow and mode-fault. It also holds the module enable, the interrupt enables, the mode-fault detection enable and the two baud-select bits. All of these drive a single registered interrupt request.

Software reaches the block over a simple register bus with three addresses: control, status and data. A read of the data register returns the byte that the datapath presents on `rx_byte`. The receive-full and overflow flags clear only through a two-step access. Software first reads the status register while a flag is set, which arms the clear. The next data-register read then completes it. A mode fault clears in a similar way: a status read that sees it set, followed by a control write.

Top module: `spi_flag_ctrl`

## Requirements
- R1: Status register (address 1), bit 7 to bit 0: receive-full, error-interrupt-enable, overflow, mode-fault, transmit-empty, mode-fault-detect-enable, baud[1:0]. A status write changes only bits 6, 2, 1 and 0. The flag bits ignore writes.
- R2: Synchronous reset leaves status reading 0x08, control reading 0x00 and `irq` at 0.
- R3: While enabled, a receive event sets receive-full.
- R4: Receive-full clears only when a data read (address 2) follows a status read that saw receive-full or overflow set. A data read without that earlier status read leaves it set. A status write or a receive event in between does not cancel the armed clear.
- R5: A receive event while receive-full is set, with no completing data read in the same cycle, sets overflow. Overflow clears through the same two-step sequence as receive-full.
- R6: When a receive event and a completing data read fall in the same cycle, receive-full stays 1 and overflow is not set.
- R7: While enabled, a mode-fault event sets mode-fault only if detect-enable is 1. Mode-fault clears on a control write that follows a status read which saw it set.
- R8: While enabled, a transmit-load event sets transmit-empty. A write to the data register clears it.
- R9: `irq` is registered. It goes high one cycle after any enabled source holds: receive-full with receive-interrupt-enable, transmit-empty with transmit-interrupt-enable, or overflow or mode-fault with error-interrupt-enable.
- R10: Control register (address 0) layout: bit 0 is module enable, bit 1 is receive-interrupt-enable, bit 2 is transmit-interrupt-enable. Read data appears on `bus_rdata` one cycle after the read strobe. A data read returns `rx_byte`.
- R11: While module enable is 0, every clock applies a partial reset. Receive-full, overflow, mode-fault and the armed clears go to 0, and transmit-empty goes to 1. Configuration bits keep their values. Events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register select: 0 control, 1 status, 2 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ev_tx_load | input | 1 | Pulse: byte moved into the shift register |
| ev_rx_done | input | 1 | Pulse: byte moved into the receive holding register |
| ev_mode_fault | input | 1 | Pulse: mode fault detected |
| rx_byte | input | DATA_W | Contents of the receive holding register |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit data and a 2-bit address. At these values every status bit lands at a fixed, known position, so one byte compare checks the flag and configuration bits together. The narrow address also reaches all three registers with a small table. Directed sequences then cover the cases the table cannot show. These include a receive event colliding with the completing data read, and a receive event between the arming read and the data read. They also cover disabling the module while flags are set, and the one-cycle lag of `irq` behind each interrupt enable.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int REG_W = 8;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_DATA = 2;

  // status bit positions
  localparam int B_RXF   = 7;
  localparam int B_ERRIE = 6;
  localparam int B_OVF   = 5;
  localparam int B_MODF  = 4;
  localparam int B_TXE   = 3;
  localparam int B_MFEN  = 2;

  // control bit positions
  localparam int C_EN   = 0;
  localparam int C_RXIE = 1;
  localparam int C_TXIE = 2;

  localparam logic [REG_W-1:0] STAT_WMASK = 8'h47;
  localparam logic [REG_W-1:0] CTRL_WMASK = 8'h07;

  // interrupt source indices
  localparam int NSRC  = 3;
  localparam int S_RX  = 0;
  localparam int S_TX  = 1;
  localparam int S_ERR = 2;
endpackage

// File: rtl/spi_flag_cfg.sv
module spi_flag_cfg
  import spi_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] scfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      scfg_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & CTRL_WMASK;
      if (wr_stat) scfg_q <= wdata & STAT_WMASK;
    end
  end
endmodule

// File: rtl/spi_flag_rx.sv
module spi_flag_rx (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ev_rx,
  input  logic rd_stat,
  input  logic rd_data,
  output logic rxf,
  output logic ovf,
  output logic armed
);
  logic clr;
  assign clr = rd_data & armed;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed <= 1'b0;
      rxf   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (rd_data)                    armed <= 1'b0;
      else if (rd_stat && (rxf || ovf)) armed <= 1'b1;

      if (ev_rx)    rxf <= 1'b1;
      else if (clr) rxf <= 1'b0;

      if (ev_rx && rxf && !clr) ovf <= 1'b1;
      else if (clr)             ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_flag_irq.sv
module spi_flag_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic [N-1:0] gate,
  output logic         irq
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = src[i] & gate[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |hit;
  end
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ev_tx_load,
  input  logic              ev_rx_done,
  input  logic              ev_mode_fault,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              irq
);
  logic sel_ctrl, sel_stat, sel_data;
  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data;
  logic [REG_W-1:0] ctrl_q, scfg_q, stat_rd;
  logic en, rxf, ovf, rx_armed;
  logic txe, modf, mf_armed;
  logic [NSRC-1:0] src, gate;

  assign sel_ctrl = (bus_addr == ADDR_W'(A_CTRL));
  assign sel_stat = (bus_addr == ADDR_W'(A_STAT));
  assign sel_data = (bus_addr == ADDR_W'(A_DATA));
  assign wr_ctrl  = bus_wr & sel_ctrl;
  assign wr_stat  = bus_wr & sel_stat;
  assign wr_data  = bus_wr & sel_data;
  assign rd_stat  = bus_rd & sel_stat;
  assign rd_data  = bus_rd & sel_data;

  spi_flag_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .scfg_q(scfg_q)
  );

  assign en = ctrl_q[C_EN];

  spi_flag_rx u_rx (
    .clk(clk), .rst(rst), .en(en), .ev_rx(ev_rx_done),
    .rd_stat(rd_stat), .rd_data(rd_data),
    .rxf(rxf), .ovf(ovf), .armed(rx_armed)
  );

  // transmit-empty and mode-fault flags
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      txe      <= 1'b1;
      modf     <= 1'b0;
      mf_armed <= 1'b0;
    end else begin
      if (ev_tx_load)   txe <= 1'b1;
      else if (wr_data) txe <= 1'b0;

      if (wr_ctrl)             mf_armed <= 1'b0;
      else if (rd_stat && modf) mf_armed <= 1'b1;

      if (ev_mode_fault && scfg_q[B_MFEN]) modf <= 1'b1;
      else if (wr_ctrl && mf_armed)        modf <= 1'b0;
    end
  end

  always_comb begin
    stat_rd         = scfg_q;
    stat_rd[B_RXF]  = rxf;
    stat_rd[B_OVF]  = ovf;
    stat_rd[B_MODF] = modf;
    stat_rd[B_TXE]  = txe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_ctrl)      bus_rdata <= DATA_W'(ctrl_q);
      else if (sel_stat) bus_rdata <= DATA_W'(stat_rd);
      else if (sel_data) bus_rdata <= rx_byte;
      else               bus_rdata <= '0;
    end
  end

  assign src[S_RX]   = rxf;
  assign src[S_TX]   = txe;
  assign src[S_ERR]  = ovf | modf;
  assign gate[S_RX]  = ctrl_q[C_RXIE];
  assign gate[S_TX]  = ctrl_q[C_TXIE];
  assign gate[S_ERR] = scfg_q[B_ERRIE];

  spi_flag_irq #(.N(NSRC)) u_irq (
    .clk(clk), .rst(rst), .src(src), .gate(gate), .irq(irq)
  );
endmodule

// File: rtl/spi_flag_chk.sv
module spi_flag_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic ev_rx,
  input logic ev_tx,
  input logic rd_data,
  input logic rx_armed,
  input logic rxf,
  input logic ovf,
  input logic txe,
  input logic modf,
  input logic mf_en,
  input logic irq
);
  a_r3_rx_sets: assert property (@(posedge clk) disable iff (rst)
    (en && ev_rx) |=> rxf);

  a_r4_rxf_holds: assert property (@(posedge clk) disable iff (rst)
    (en && rxf && !rd_data) |=> rxf);

  a_r5_overflow: assert property (@(posedge clk) disable iff (rst)
    (en && ev_rx && rxf && !(rd_data && rx_armed)) |=> ovf);

  a_r7_no_detect: assert property (@(posedge clk) disable iff (rst)
    (en && !mf_en && !modf) |=> !modf);

  a_r8_tx_sets: assert property (@(posedge clk) disable iff (rst)
    (en && ev_tx) |=> txe);

  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(rxf || txe || ovf || modf));

  a_r11_partial_reset: assert property (@(posedge clk) disable iff (rst)
    !en |=> (txe && !rxf && !ovf && !modf));
endmodule

bind spi_flag_ctrl spi_flag_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .ev_rx(ev_rx_done), .ev_tx(ev_tx_load),
  .rd_data(rd_data), .rx_armed(rx_armed), .rxf(rxf), .ovf(ovf),
  .txe(txe), .modf(modf), .mf_en(scfg_q[2]), .irq(irq)
);

// File: tb/spi_flag_ctrl_tb.sv
module spi_flag_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ev_tx_load = 1'b0, ev_rx_done = 1'b0, ev_mode_fault = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       irq;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_flag_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_tx_load(ev_tx_load),
    .ev_rx_done(ev_rx_done), .ev_mode_fault(ev_mode_fault), .rx_byte(rx_byte),
    .irq(irq)
  );

  // entry: [35:32] req, [31:30] op (0 idle,1 rd,2 wr), [29:28] addr,
  // [27:20] wdata, [19:17] events {tx,rx,mf}, [16:9] rx_byte, [8] check, [7:0] expected
  function automatic logic [35:0] mk(input int req, input int op, input int ad,
      input logic [7:0] wd, input logic [2:0] ev, input logic [7:0] rb,
      input logic ck, input logic [7:0] ex);
    return {4'(req), 2'(op), 2'(ad), wd, ev, rb, ck, ex};
  endfunction

  localparam int NV = 28;
  localparam logic [35:0] VEC [NV] = '{
    mk(2, 1,1,8'h00,3'b000,8'h00,1,8'h08),  // R2 reset status
    mk(10,2,0,8'h01,3'b000,8'h00,0,8'h00),  // R10 enable
    mk(10,1,0,8'h00,3'b000,8'h00,1,8'h01),  // R10 control readback
    mk(1, 2,1,8'hFF,3'b000,8'h00,0,8'h00),  // R1 write all ones
    mk(1, 1,1,8'h00,3'b000,8'h00,1,8'h4F),  // R1 flags ignore writes
    mk(3, 0,0,8'h00,3'b010,8'hA5,0,8'h00),  // R3 receive
    mk(3, 1,1,8'h00,3'b000,8'h00,1,8'hCF),  // R3 receive-full set
    mk(5, 0,0,8'h00,3'b010,8'h3C,0,8'h00),  // R5 second byte
    mk(5, 1,1,8'h00,3'b000,8'h3C,1,8'hEF),  // R5 overflow set
    mk(4, 2,1,8'h47,3'b000,8'h3C,0,8'h00),  // R4 write keeps arm
    mk(10,1,2,8'h00,3'b000,8'h3C,1,8'h3C),  // R10 data read
    mk(4, 1,1,8'h00,3'b000,8'h3C,1,8'h4F),  // R4 R5 cleared
    mk(3, 0,0,8'h00,3'b010,8'h11,0,8'h00),  // R3 receive
    mk(4, 1,2,8'h00,3'b000,8'h11,1,8'h11),  // R4 unarmed data read
    mk(4, 1,1,8'h00,3'b000,8'h11,1,8'hCF),  // R4 still set
    mk(4, 1,2,8'h00,3'b000,8'h11,1,8'h11),  // R4 armed data read
    mk(4, 1,1,8'h00,3'b000,8'h11,1,8'h4F),  // R4 cleared
    mk(7, 0,0,8'h00,3'b001,8'h00,0,8'h00),  // R7 fault
    mk(7, 1,1,8'h00,3'b000,8'h00,1,8'h5F),  // R7 set, arms
    mk(7, 2,0,8'h01,3'b000,8'h00,0,8'h00),  // R7 control write
    mk(7, 1,1,8'h00,3'b000,8'h00,1,8'h4F),  // R7 cleared
    mk(8, 2,2,8'h00,3'b000,8'h00,0,8'h00),  // R8 data write
    mk(8, 1,1,8'h00,3'b000,8'h00,1,8'h47),  // R8 cleared
    mk(8, 0,0,8'h00,3'b100,8'h00,0,8'h00),  // R8 load
    mk(8, 1,1,8'h00,3'b000,8'h00,1,8'h4F),  // R8 set
    mk(7, 2,1,8'h00,3'b000,8'h00,0,8'h00),  // R7 detect off
    mk(7, 0,0,8'h00,3'b001,8'h00,0,8'h00),  // R7 fault ignored
    mk(7, 1,1,8'h00,3'b000,8'h00,1,8'h08)   // R7 still clear
  };

  task automatic op(input int kind, input int ad, input logic [7:0] wd,
                    input logic [2:0] ev, input logic [7:0] rb);
    bus_rd = (kind == 1); bus_wr = (kind == 2);
    bus_addr = 2'(ad); bus_wdata = wd;
    {ev_tx_load, ev_rx_done, ev_mode_fault} = ev;
    rx_byte = rb;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    {ev_tx_load, ev_rx_done, ev_mode_fault} = 3'b000;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input int ad, input logic [7:0] rb,
                        input logic [7:0] exp);
    op(1, ad, 8'h00, 3'b000, rb);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R2 irq after reset", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op(int'(VEC[i][31:30]), int'(VEC[i][29:28]), VEC[i][27:20], VEC[i][19:17], VEC[i][16:9]);
      if (VEC[i][8])
        check($sformatf("R%0d table step %0d", VEC[i][35:32], i), bus_rdata, VEC[i][7:0]);
    end

    // R9 interrupt gating and one-cycle lag
    check("R9 txe without enable", {7'd0, irq}, 8'h00);
    op(2, 0, 8'h05, 3'b000, 8'h00);
    check("R9 lag after enable", {7'd0, irq}, 8'h00);
    op(0, 0, 8'h00, 3'b000, 8'h00);
    check("R9 tx interrupt", {7'd0, irq}, 8'h01);
    op(2, 0, 8'h01, 3'b000, 8'h00);
    op(2, 2, 8'h00, 3'b000, 8'h00);
    op(0, 0, 8'h00, 3'b000, 8'h00);
    check("R9 tx disabled", {7'd0, irq}, 8'h00);
    op(0, 0, 8'h00, 3'b010, 8'h55);
    op(2, 0, 8'h03, 3'b000, 8'h55);
    op(0, 0, 8'h00, 3'b000, 8'h55);
    check("R9 rx interrupt", {7'd0, irq}, 8'h01);
    op(2, 0, 8'h01, 3'b010, 8'h66);
    op(0, 0, 8'h00, 3'b000, 8'h66);
    check("R9 error gated off", {7'd0, irq}, 8'h00);
    op(2, 1, 8'h40, 3'b000, 8'h66);
    op(0, 0, 8'h00, 3'b000, 8'h66);
    check("R9 error interrupt", {7'd0, irq}, 8'h01);

    // R6 same-cycle receive and completing read
    rd_chk("R6 status arm", 1, 8'h66, 8'hE0);
    op(1, 2, 8'h00, 3'b010, 8'h77);
    check("R6 data value", bus_rdata, 8'h77);
    rd_chk("R6 set wins", 1, 8'h77, 8'hC0);

    // R4 receive event between arming read and data read
    rd_chk("R4 arm", 1, 8'h77, 8'hC0);
    op(0, 0, 8'h00, 3'b010, 8'h88);
    op(1, 2, 8'h00, 3'b000, 8'h88);
    rd_chk("R4 arm survives receive", 1, 8'h88, 8'h40);

    // R11 partial reset
    op(0, 0, 8'h00, 3'b010, 8'h99);
    op(2, 0, 8'h00, 3'b000, 8'h99);
    op(0, 0, 8'h00, 3'b000, 8'h99);
    rd_chk("R11 flags reset, config kept", 1, 8'h99, 8'h48);
    op(0, 0, 8'h00, 3'b111, 8'h99);
    rd_chk("R11 events ignored", 1, 8'h99, 8'h48);

    // R2 reset mid-run
    op(2, 0, 8'h07, 3'b000, 8'h00);
    op(0, 0, 8'h00, 3'b010, 8'h00);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R2 irq cleared", {7'd0, irq}, 8'h00);
    rd_chk("R2 status after reset", 1, 8'h00, 8'h08);
    rd_chk("R2 control after reset", 0, 8'h00, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule